// File: doc/BRIEF.md
# HDLC Bit-Level Frame Transmitter

This block turns a stream of tagged bytes into HDLC frames on a single NRZ serial line. It sends one bit for each cycle in which the bit-enable strobe is high. A frame is built from an opening flag, the data bytes, a 16-bit frame check sequence and a closing flag. Zero insertion runs over the data and the check sequence so that no flag pattern can appear inside a frame. A byte tagged for abort is replaced by eight ones, which ends the frame at once. The line fill between frames is picked by a 2-bit mode input. It can be continuous ones, back-to-back flags or a repeating Go-Ahead pattern. A one-bit end-of-packet pulse marks the last bit of every closing flag and every abort.

Bytes arrive on a valid/ready stream. A byte is taken on a clock edge where both `in_valid` and `in_ready` are high. `in_ready` is only raised during a bit-enable cycle at a symbol boundary where the serializer needs a byte, and it may depend on `in_valid` in that same cycle. Once the source raises `in_valid`, it must hold the byte and its tags steady until the byte is taken. The block may keep `in_ready` low for any number of cycles. Inside a frame the source must stay ahead of the line. If no byte is offered when one is needed, the frame is aborted. Frames must carry at least two data bytes; the block does not check this.

Top module: `hdlc_frame_tx`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears to the between-frames state: `tx_bit` is 1, `tx_eop` is 0, `in_ready` is 0 and the stuffing count is zero.
- R2: `tx_bit` and `tx_eop` change only on clock edges where `bit_en` is high. `in_ready` is never high without `bit_en`.
- R3: Between frames, `fill_mode` selects the fill. The value 00 (or 11) sends a single 1 per symbol. The value 01 sends flags, 0x7E least significant bit first (0,1,1,1,1,1,1,0). The fill is re-evaluated at each fill-symbol boundary.
- R4: With `fill_mode` = 10, the line repeats the 9-bit Go-Ahead symbol 0,1,1,1,1,1,1,1,0. No byte is accepted in this state, even while one is offered, until the mode changes.
- R5: A byte offered with `in_first`=1 at a fill boundary (mode not 10) starts a frame. The frame is an opening flag 0x7E, then each data byte least significant bit first, then the 16-bit check sequence, then a closing flag 0x7E. The byte tagged `in_last` is the final data byte. The first byte is taken when the opening flag completes.
- R6: The check sequence uses generator x^16+x^12+x^5+1, processed LSB-first with a 0xFFFF preset at each frame start, over every data bit. The ones' complement of the remainder is sent low-order bit first. The bytes "123456789" give the sent bytes 0x6E then 0x90. Running the same computation over the data and the sent sequence leaves 0xF0B8.
- R7: After any five consecutive ones in the data or the check sequence, including runs across byte boundaries and the last bits of the check sequence, one 0 is inserted. Flags, aborts and fills are never stuffed.
- R8: A data-phase byte offered with `in_abort`=1 is taken and replaced on the line by eight ones. The frame then ends and the line returns to the fill.
- R9: If no byte is offered at a point in a frame where a data byte is needed (after the opening flag, or after a byte without `in_last`), the block sends an abort of eight ones instead.
- R10: `tx_eop` is high for exactly one bit period, during the last bit of a closing flag or of an abort, and is low otherwise.
- R11: A byte offered between frames without `in_first` (mode not 10) is taken at the fill boundary and discarded. The line keeps the fill.
- R12: A byte is taken exactly on the edges where `in_valid` and `in_ready` are both high. `in_ready` is high only at a symbol boundary where the rules above take a byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | Bit strobe: one line bit per high cycle |
| fill_mode | input | 2 | Interframe fill: 00 ones, 01 flags, 10 Go-Ahead, 11 ones |
| in_valid | input | 1 | Byte stream valid |
| in_ready | output | 1 | Byte stream ready |
| in_data | input | 8 | Byte to send, bit 0 goes out first |
| in_first | input | 1 | Byte opens a new frame |
| in_last | input | 1 | Byte is the final data byte of its frame |
| in_abort | input | 1 | Send an abort in place of this byte |
| tx_bit | output | 1 | Serial NRZ line output |
| tx_eop | output | 1 | End-of-packet pulse, one bit period |

## Verification
A behavioural model in the bench rebuilds the expected line bit by bit and is compared on every clock. The frames are chosen to separate the failure modes. Plain small bytes confirm bit order and the check sequence. Runs of 0xFF and 0x7E confirm stuffing across byte ends, while a strobe on every third cycle confirms that the line holds between strobes. The "123456789" frame ties the check sequence to a known value. Frames that run dry, carry an abort tag, or offer an untagged byte between frames show the three ways a byte can end or skip a frame. A frame queued during Go-Ahead shows that the fill is sticky and gives way only on a mode change.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;
  typedef enum logic [2:0] {
    SYM_FILL, SYM_OPEN, SYM_DATA, SYM_FCS, SYM_CLOSE, SYM_ABORT
  } sym_e;

  localparam int SYM_W = 16;
  localparam int LIM_W = $clog2(SYM_W);
  localparam int CNT_W = LIM_W + 1;

  localparam logic [1:0] FILL_IDLE = 2'b00;
  localparam logic [1:0] FILL_FLAG = 2'b01;
  localparam logic [1:0] FILL_GOAHEAD = 2'b10;

  localparam logic [7:0] FLAG_BYTE = 8'h7E;
  localparam logic [7:0] ABORT_BYTE = 8'hFF;
  localparam int GA_LEN = 9;
  localparam logic [GA_LEN-1:0] GA_SYMBOL = 9'h0FE;

  localparam int FCS_W = 16;
  localparam logic [FCS_W-1:0] FCS_PRESET = 16'hFFFF;
  localparam logic [FCS_W-1:0] FCS_POLY_LSB = 16'h8408;
endpackage

// File: rtl/hdlc_tx_fcs.sv
module hdlc_tx_fcs import hdlc_tx_pkg::*; #(
  parameter int W = FCS_W,
  parameter logic [W-1:0] POLY = FCS_POLY_LSB,
  parameter logic [W-1:0] PRESET = FCS_PRESET
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         advance,
  input  logic         din,
  output logic [W-1:0] crc
);
  logic         fb;
  logic [W-1:0] shifted;

  assign fb      = crc[0] ^ din;
  assign shifted = {1'b0, crc[W-1:1]};

  always_ff @(posedge clk) begin
    if (!rst_n || clear) crc <= PRESET;
    else if (advance)    crc <= fb ? (shifted ^ POLY) : shifted;
  end
endmodule

// File: rtl/hdlc_tx_symsel.sv
module hdlc_tx_symsel import hdlc_tx_pkg::*; (
  input  sym_e             prev_st,
  input  logic             prev_last,
  input  logic [1:0]       fill_mode,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_first,
  input  logic             in_last,
  input  logic             in_abort,
  input  logic [FCS_W-1:0] fcs_word,
  output sym_e             nxt_st,
  output logic [SYM_W-1:0] nxt_sh,
  output logic [LIM_W-1:0] nxt_lim,
  output logic             nxt_last,
  output logic             take
);
  localparam logic [LIM_W-1:0] LIM_BYTE = LIM_W'(7);
  localparam logic [LIM_W-1:0] LIM_GA   = LIM_W'(GA_LEN - 1);
  localparam logic [LIM_W-1:0] LIM_FCS  = LIM_W'(FCS_W - 1);

  logic between;
  logic need_byte;

  assign between   = (prev_st == SYM_FILL) || (prev_st == SYM_CLOSE) || (prev_st == SYM_ABORT);
  assign need_byte = (prev_st == SYM_OPEN) || ((prev_st == SYM_DATA) && !prev_last);

  always_comb begin
    nxt_st   = SYM_FILL;
    nxt_sh   = SYM_W'(1);
    nxt_lim  = '0;
    nxt_last = 1'b0;
    take     = 1'b0;
    if (between) begin
      if (fill_mode == FILL_GOAHEAD) begin
        nxt_sh  = SYM_W'(GA_SYMBOL);
        nxt_lim = LIM_GA;
      end else if (in_valid && in_first) begin
        nxt_st  = SYM_OPEN;
        nxt_sh  = SYM_W'(FLAG_BYTE);
        nxt_lim = LIM_BYTE;
      end else begin
        take = in_valid;
        if (fill_mode == FILL_FLAG) begin
          nxt_sh  = SYM_W'(FLAG_BYTE);
          nxt_lim = LIM_BYTE;
        end
      end
    end else if (need_byte) begin
      take = in_valid;
      if (!in_valid || in_abort) begin
        nxt_st  = SYM_ABORT;
        nxt_sh  = SYM_W'(ABORT_BYTE);
        nxt_lim = LIM_BYTE;
      end else begin
        nxt_st   = SYM_DATA;
        nxt_sh   = SYM_W'(in_data);
        nxt_lim  = LIM_BYTE;
        nxt_last = in_last;
      end
    end else if (prev_st == SYM_DATA) begin
      nxt_st  = SYM_FCS;
      nxt_sh  = SYM_W'(fcs_word);
      nxt_lim = LIM_FCS;
    end else begin
      nxt_st  = SYM_CLOSE;
      nxt_sh  = SYM_W'(FLAG_BYTE);
      nxt_lim = LIM_BYTE;
    end
  end
endmodule

// File: rtl/hdlc_frame_tx.sv
module hdlc_frame_tx import hdlc_tx_pkg::*; #(
  parameter int STUFF_RUN = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic [1:0] fill_mode,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_first,
  input  logic       in_last,
  input  logic       in_abort,
  output logic       tx_bit,
  output logic       tx_eop
);
  localparam int OW = $clog2(STUFF_RUN + 1);
  localparam logic [OW-1:0] RUN_MAX = OW'(STUFF_RUN);

  sym_e             st_q, n_st, cur_st;
  logic [SYM_W-1:0] sh_q, n_sh, cur_sh;
  logic [LIM_W-1:0] lim_q, n_lim, cur_lim;
  logic [CNT_W-1:0] cnt_q, cur_cnt;
  logic             last_q, n_last, cur_last;
  logic             empty_q, n_take;
  logic [OW-1:0]    ones_q, ones_nx;
  logic [FCS_W-1:0] crc_q;
  logic             body, stuff, bit_out, at_end, finish, eop_nx;
  logic             crc_clr, crc_adv;

  hdlc_tx_symsel u_sel (
    .prev_st   (st_q),
    .prev_last (last_q),
    .fill_mode (fill_mode),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_first  (in_first),
    .in_last   (in_last),
    .in_abort  (in_abort),
    .fcs_word  (~crc_q),
    .nxt_st    (n_st),
    .nxt_sh    (n_sh),
    .nxt_lim   (n_lim),
    .nxt_last  (n_last),
    .take      (n_take)
  );

  hdlc_tx_fcs u_fcs (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (crc_clr),
    .advance (crc_adv),
    .din     (bit_out),
    .crc     (crc_q)
  );

  // At a symbol boundary the freshly chosen symbol emits its first bit at once.
  assign cur_st   = empty_q ? n_st   : st_q;
  assign cur_sh   = empty_q ? n_sh   : sh_q;
  assign cur_lim  = empty_q ? n_lim  : lim_q;
  assign cur_last = empty_q ? n_last : last_q;
  assign cur_cnt  = empty_q ? '0     : cnt_q;

  assign in_ready = rst_n && bit_en && empty_q && n_take;

  assign body    = (cur_st == SYM_DATA) || (cur_st == SYM_FCS);
  assign stuff   = body && (ones_q == RUN_MAX);
  assign bit_out = stuff ? 1'b0 : cur_sh[cur_cnt[LIM_W-1:0]];
  assign at_end  = (cur_cnt == {1'b0, cur_lim});

  always_comb begin
    if (!body || stuff)  ones_nx = '0;
    else if (bit_out)    ones_nx = ones_q + 1'b1;
    else                 ones_nx = '0;
  end

  assign finish  = stuff ? (cur_cnt > {1'b0, cur_lim}) : (at_end && (ones_nx != RUN_MAX));
  assign eop_nx  = ((cur_st == SYM_CLOSE) || (cur_st == SYM_ABORT)) && at_end;
  assign crc_clr = bit_en && empty_q && (n_st == SYM_OPEN);
  assign crc_adv = bit_en && (cur_st == SYM_DATA) && !stuff;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= SYM_FILL;
      sh_q    <= '0;
      lim_q   <= '0;
      cnt_q   <= '0;
      last_q  <= 1'b0;
      empty_q <= 1'b1;
      ones_q  <= '0;
      tx_bit  <= 1'b1;
      tx_eop  <= 1'b0;
    end else if (bit_en) begin
      st_q   <= cur_st;
      sh_q   <= cur_sh;
      lim_q  <= cur_lim;
      last_q <= cur_last;
      ones_q <= ones_nx;
      tx_bit <= bit_out;
      tx_eop <= eop_nx;
      if (finish) begin
        empty_q <= 1'b1;
        cnt_q   <= '0;
      end else begin
        empty_q <= 1'b0;
        cnt_q   <= stuff ? cur_cnt : cur_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/hdlc_tx_checker.sv
module hdlc_tx_checker import hdlc_tx_pkg::*; (
  input logic       clk,
  input logic       rst_n,
  input logic       bit_en,
  input logic [1:0] fill_mode,
  input logic       in_ready,
  input logic       tx_bit,
  input logic       tx_eop,
  input sym_e       st
);
  logic       en_d;
  logic [3:0] run_q, run_c;

  always_comb begin
    if (!en_d)       run_c = run_q;
    else if (tx_bit) run_c = (run_q == 4'hF) ? run_q : run_q + 1'b1;
    else             run_c = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_d  <= 1'b0;
      run_q <= '0;
    end else begin
      en_d  <= bit_en;
      run_q <= run_c;
    end
  end

  // R2: line holds between strobes
  p_hold_between_strobes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> ($stable(tx_bit) && $stable(tx_eop)));

  // R2: stream accepted only in a strobe cycle
  p_ready_needs_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> bit_en);

  // R10: end-of-packet lasts one bit period
  p_eop_single_bit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_eop && bit_en) |=> !tx_eop);

  // R7: never six ones inside the frame body
  p_stuffed_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == SYM_DATA) || (st == SYM_FCS)) |-> (run_c <= 4'd5));

  // R4: Go-Ahead fill takes no bytes
  p_goahead_no_take_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (((st == SYM_FILL) || (st == SYM_CLOSE) || (st == SYM_ABORT)) && (fill_mode == FILL_GOAHEAD))
      |-> !in_ready);
endmodule

bind hdlc_frame_tx hdlc_tx_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bit_en    (bit_en),
  .fill_mode (fill_mode),
  .in_ready  (in_ready),
  .tx_bit    (tx_bit),
  .tx_eop    (tx_eop),
  .st        (st_q)
);

// File: tb/test_hdlc_frame_tx.sv
module test_hdlc_frame_tx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_en = 1'b0;
  logic [1:0] fill_mode = 2'b00;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = '0;
  logic       in_first = 1'b0, in_last = 1'b0, in_abort = 1'b0;
  logic       tx_bit, tx_eop;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int div = 1;
  string req = "R1";

  logic [10:0] src_q[$];
  bit          exp_q[$];
  bit          eopq[$];
  int          m_prev = 0;
  bit          m_last = 0;
  int          m_ones = 0;
  logic [15:0] m_crc = 16'hFFFF;
  bit          exp_bit = 1, exp_eop = 0;

  always #4 clk = ~clk;

  hdlc_frame_tx i_hdlc_frame_tx (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .fill_mode(fill_mode),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_first(in_first), .in_last(in_last), .in_abort(in_abort),
    .tx_bit(tx_bit), .tx_eop(tx_eop));

  task automatic check(string r, bit ok, int got, int want, string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h (cycle %0d)", r, what, got, want, cyc);
    end
  endtask

  function automatic logic [15:0] crc_step(logic [15:0] c, bit b);
    logic [15:0] r;
    r = {1'b0, c[15:1]};
    if (c[0] ^ b) r = r ^ 16'h8408;
    return r;
  endfunction

  task automatic push_plain(logic [15:0] v, int n, bit eop_end);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(v[i]);
      eopq.push_back(eop_end && (i == n - 1));
    end
  endtask

  task automatic push_stuffed(logic [7:0] v, bit is_data);
    for (int i = 0; i < 8; i++) begin
      exp_q.push_back(v[i]);
      eopq.push_back(0);
      if (is_data) m_crc = crc_step(m_crc, v[i]);
      if (v[i]) m_ones++; else m_ones = 0;
      if (m_ones == 5) begin
        exp_q.push_back(0);
        eopq.push_back(0);
        m_ones = 0;
      end
    end
  endtask

  // reference model: decides each symbol from the requirements, on the strobe edge
  always @(posedge clk) begin
    bit take, got;
    logic [15:0] fcs, res;
    cyc++;
    if (!rst_n) begin
      exp_q.delete(); eopq.delete();
      m_prev = 0; m_ones = 0; exp_bit = 1; exp_eop = 0;
    end else begin
      take = 0;
      if (bit_en) begin
        if (exp_q.size() == 0) begin
          if (m_prev == 0 || m_prev == 4 || m_prev == 5) begin
            if (fill_mode == 2'b10) begin
              push_plain(16'h00FE, 9, 0); m_prev = 0;
            end else if (in_valid && in_first) begin
              push_plain(16'h007E, 8, 0); m_prev = 1; m_crc = 16'hFFFF; m_ones = 0;
            end else begin
              take = in_valid;
              if (fill_mode == 2'b01) push_plain(16'h007E, 8, 0);
              else push_plain(16'h0001, 1, 0);
              m_prev = 0;
            end
          end else if (m_prev == 1 || (m_prev == 2 && !m_last)) begin
            take = in_valid;
            if (!in_valid || in_abort) begin
              push_plain(16'h00FF, 8, 1); m_prev = 5;
            end else begin
              push_stuffed(in_data, 1); m_last = in_last; m_prev = 2;
            end
          end else if (m_prev == 2) begin
            fcs = ~m_crc;
            res = m_crc;
            for (int i = 0; i < 16; i++) res = crc_step(res, fcs[i]);
            check("R6", res == 16'hF0B8, res, 16'hF0B8, "receiver residue");
            push_stuffed(fcs[7:0], 0);
            push_stuffed(fcs[15:8], 0);
            m_prev = 3;
          end else begin
            push_plain(16'h007E, 8, 1); m_prev = 4; m_ones = 0;
          end
        end
        exp_bit = exp_q.pop_front();
        exp_eop = eopq.pop_front();
      end
      got = in_valid && in_ready;
      check("R12", got == take, got, take, "byte handshake");
      if (got) void'(src_q.pop_front());
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check(req, tx_bit == exp_bit, tx_bit, exp_bit, "line bit");
      check("R10", tx_eop == exp_eop, tx_eop, exp_eop, "end-of-packet");
    end
    bit_en <= ((cyc % div) == 0);
    in_valid <= (src_q.size() > 0);
    if (src_q.size() > 0) {in_abort, in_last, in_first, in_data} <= src_q[0];
  end

  task automatic push_byte(logic [7:0] d, bit f, bit l, bit a);
    src_q.push_back({a, l, f, d});
  endtask

  task automatic run(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic drain(int n);
    while (src_q.size() > 0) @(posedge clk);
    run(n);
  endtask

  initial begin
    while (cyc < 150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] c;
    run(4);
    @(negedge clk);
    check("R1", tx_bit == 1'b1, tx_bit, 1, "reset line");
    check("R1", tx_eop == 1'b0, tx_eop, 0, "reset eop");
    check("R1", in_ready == 1'b0, in_ready, 0, "reset ready");
    rst_n = 1'b1;

    // R6: model FCS against the known check value
    c = 16'hFFFF;
    for (int k = 0; k < 9; k++)
      for (int i = 0; i < 8; i++) c = crc_step(c, (8'h31 + k) >> i);
    check("R6", ~c == 16'h906E, ~c, 16'h906E, "check value of 123456789");

    req = "R3"; fill_mode = 2'b00; run(40);
    fill_mode = 2'b01; run(60);

    req = "R5";
    push_byte(8'h12, 1, 0, 0); push_byte(8'h34, 0, 0, 0); push_byte(8'h56, 0, 1, 0);
    drain(80);

    req = "R7"; div = 3;
    push_byte(8'hFF, 1, 0, 0); push_byte(8'h7E, 0, 0, 0); push_byte(8'hF8, 0, 0, 0);
    push_byte(8'h3F, 0, 1, 0);
    drain(300);
    req = "R2"; run(60);

    req = "R6"; div = 1; fill_mode = 2'b00;
    for (int k = 0; k < 9; k++) push_byte(8'h31 + k, k == 0, k == 8, 0);
    drain(80);

    req = "R8";
    push_byte(8'hA5, 1, 0, 0); push_byte(8'h5A, 0, 0, 0); push_byte(8'h00, 0, 0, 1);
    drain(60);

    req = "R9";
    push_byte(8'hC3, 1, 0, 0);
    drain(80);

    req = "R11"; fill_mode = 2'b01;
    push_byte(8'hAA, 0, 0, 0);
    drain(40);
    check("R11", src_q.size() == 0, src_q.size(), 0, "untagged byte taken");

    req = "R4"; fill_mode = 2'b10; run(30);
    push_byte(8'h11, 1, 0, 0); push_byte(8'h22, 0, 1, 0);
    run(200);
    check("R4", src_q.size() == 2, src_q.size(), 2, "bytes held during Go-Ahead");
    req = "R5"; fill_mode = 2'b01;
    drain(80);
    check("R5", src_q.size() == 0, src_q.size(), 0, "frame sent after mode change");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule